// File: doc/BRIEF.md
# Dual-Clock Shift-and-Hold Register

This block turns a serial bit stream into parallel words. Bits enter a chain of shift stages, one stage per rising edge of the shift clock. A separate store clock copies the whole chain into a holding register in one step. The holding register drives the parallel outputs, so those outputs stay steady while the next word is shifted in underneath them.

The chain is built from `UNITS` identical eight-stage units. The last stage of each unit feeds the first stage of the next unit, and the last stage of the final unit is brought out as a serial output for further chaining. An active-low clear empties every shift stage at once and does not touch the holding register. An active-low output enable gates the parallel outputs. For synthesis, the gating appears as a data vector plus a per-bit drive-enable vector. The top level also resolves these into a three-state pad vector.

Top module: `shr_cascade`

## Requirements
- R1: On each rising edge of `sclk`, when `clr_n` is high, the chain shifts by one position. The input `sdin` enters global position 0, and every position p moves to position p+1. Global position p is stage p mod 8 of unit p div 8.
- R2: On each rising edge of `stclk`, the holding register copies all positions at once. After that edge, `q_o[p]` equals chain position p as it stood just before the edge.
- R3: When `sclk` and `stclk` rise together, the holding register takes the chain value from before the shift. The held word therefore lags the chain by one pulse.
- R4: While `clr_n` is low, every shift position is zero, with no clock edge needed.
- R5: `sout` always equals the highest chain position. The last stage of each unit feeds stage 0 of the next unit.
- R6: While `oe_n` is low, `q_en_o` is all ones and `q_io` equals `q_o`. While `oe_n` is high, `q_en_o` is all zeros and `q_io` is high-impedance.
- R7: The clear leaves the holding register unchanged. A store edge after a clear makes `q_o` all zeros.
- R8: `sout` is not gated by `oe_n`. When `clr_n` falls, `sout` goes low at once.
- R9: After the clear is released, a bit shifted in first reaches `q_o[7]` after 8 shift edges and reaches `sout` after 8×`UNITS` shift edges.
- R10: After 8×`UNITS` shift edges and one store edge, each unit holds its own byte of the stream. The bit shifted in k-th from the end (k = 0 for the last bit) appears at `q_o[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Shift clock, rising edge active |
| stclk | input | 1 | Store clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear of the shift stages, active low |
| oe_n | input | 1 | Parallel output enable, active low |
| sdin | input | 1 | Serial data into unit 0 stage 0 |
| sout | output | 1 | Last stage of the final unit |
| q_o | output | 8×UNITS | Holding register contents |
| q_en_o | output | 8×UNITS | Per-bit drive enable for the parallel outputs |
| q_io | output | 8×UNITS | Three-state parallel outputs |

## Verification
The bench drives both clocks in a single pulse and checks that the held word is the chain value from before that shift. A design with a race between the two clocks would instead show the freshly shifted word. It clears the chain while a nonzero word is held, then checks three things: `sout` drops with no clock edge, `q_o` keeps its value, and a later store gives zeros. A clear wired into the holding register, or a synchronous clear, breaks one of these checks. It also walks a single one through the whole cascade and counts edges to the unit boundary and to `sout`. A missing or doubled link between units moves that arrival by eight edges. With `oe_n` high it checks that the drive enables are released while `sout` keeps tracking the chain.

// File: rtl/shr_pkg.sv
package shr_pkg;
    localparam int unsigned SHR_STAGES_DEF = 8;
    localparam int unsigned SHR_UNITS_DEF  = 2;
endpackage

// File: rtl/shr_chain.sv
module shr_chain #(
    parameter int unsigned W = shr_pkg::SHR_STAGES_DEF
) (
    input  logic         sclk,
    input  logic         clr_n,
    input  logic         sin,
    output logic [W-1:0] stages,
    output logic         sout
);
    typedef struct packed {
        logic [W-1:0] st;
    } chain_t;

    chain_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.st = {s_q.st[W-2:0], sin};
    end

    always_ff @(posedge sclk or negedge clr_n) begin
        if (!clr_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stages = s_q.st;
    assign sout   = s_q.st[W-1];

    // R1: one-position shift with serial entry at stage 0
    a_r1_shift_step: assert property (@(posedge sclk) disable iff (!clr_n)
        1'b1 |=> stages == {$past(stages[W-2:0]), $past(sin)});

    // R4: clear holds every stage at zero
    a_r4_clear_zero: assert property (@(posedge sclk)
        !clr_n |-> stages == '0);
endmodule

// File: rtl/shr_hold.sv
module shr_hold #(
    parameter int unsigned W = shr_pkg::SHR_STAGES_DEF
) (
    input  logic         stclk,
    input  logic         clr_n,
    input  logic [W-1:0] snap_i,
    output logic [W-1:0] hold_o
);
    typedef struct packed {
        logic [W-1:0] h;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d   = h_q;
        h_d.h = snap_i;
    end

    always_ff @(posedge stclk) begin
        h_q <= h_d;
    end

    assign hold_o = h_q.h;

    // R2: snapshot equals the chain value sampled at the store edge
    a_r2_snapshot: assert property (@(posedge stclk) disable iff (!clr_n)
        1'b1 |=> hold_o == $past(snap_i));
endmodule

// File: rtl/shr_oe_gate.sv
module shr_oe_gate #(
    parameter int unsigned N = 16
) (
    input  logic         oe_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] d_o,
    output logic [N-1:0] en_o
);
    always_comb begin
        d_o  = d_i;
        en_o = {N{~oe_n}};
    end
endmodule

// File: rtl/shr_cascade.sv
module shr_cascade #(
    parameter int unsigned STAGES = shr_pkg::SHR_STAGES_DEF,
    parameter int unsigned UNITS  = shr_pkg::SHR_UNITS_DEF
) (
    input  logic                      sclk,
    input  logic                      stclk,
    input  logic                      clr_n,
    input  logic                      oe_n,
    input  logic                      sdin,
    output logic                      sout,
    output logic [STAGES*UNITS-1:0]   q_o,
    output logic [STAGES*UNITS-1:0]   q_en_o,
    output wire  [STAGES*UNITS-1:0]   q_io
);
    localparam int unsigned TOT = STAGES * UNITS;

    logic [UNITS:0]      link;
    logic [STAGES-1:0]   stg  [UNITS];
    logic [TOT-1:0]      held;

    assign link[0] = sdin;

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        shr_chain #(.W(STAGES)) u_chain (
            .sclk   (sclk),
            .clr_n  (clr_n),
            .sin    (link[u]),
            .stages (stg[u]),
            .sout   (link[u+1])
        );
        shr_hold #(.W(STAGES)) u_hold (
            .stclk  (stclk),
            .clr_n  (clr_n),
            .snap_i (stg[u]),
            .hold_o (held[u*STAGES +: STAGES])
        );
    end

    for (genvar u = 0; u + 1 < UNITS; u++) begin : g_link_chk
        // R5: last stage of one unit feeds stage 0 of the next
        a_r5_cascade: assert property (@(posedge sclk) disable iff (!clr_n)
            1'b1 |=> stg[u+1][0] == $past(stg[u][STAGES-1]));
    end

    shr_oe_gate #(.N(TOT)) u_gate (
        .oe_n (oe_n),
        .d_i  (held),
        .d_o  (q_o),
        .en_o (q_en_o)
    );

    for (genvar b = 0; b < TOT; b++) begin : g_pad
        assign q_io[b] = q_en_o[b] ? q_o[b] : 1'bz;
    end

    assign sout = link[UNITS];

    // R6: drive enables released while the enable input is high
    a_r6_release: assert property (@(posedge stclk) disable iff (!clr_n)
        oe_n |-> q_en_o == '0);

    // R8: serial output low whenever the clear is active
    a_r8_sout_cleared: assert property (@(posedge sclk)
        !clr_n |-> !sout);
endmodule

// File: tb/sim_shr_cascade.sv
module sim_shr_cascade;
    localparam int unsigned STAGES = 8;
    localparam int unsigned UNITS  = 2;
    localparam int unsigned TOT    = STAGES * UNITS;
    localparam int CLK_PERIOD = 10;

    logic sclk = 0, stclk = 0, clr_n = 0, oe_n = 1, sdin = 0;
    logic sout;
    logic [TOT-1:0] q_o, q_en_o;
    wire  [TOT-1:0] q_io;

    shr_cascade #(.STAGES(STAGES), .UNITS(UNITS)) u0 (
        .sclk(sclk), .stclk(stclk), .clr_n(clr_n), .oe_n(oe_n), .sdin(sdin),
        .sout(sout), .q_o(q_o), .q_en_o(q_en_o), .q_io(q_io)
    );

    typedef struct {
        logic [TOT-1:0] v;
        string          tag;
    } exp_t;

    exp_t           sb[$];
    logic [TOT-1:0] mdl = '0;
    int checks = 0, errors = 0;
    bit done = 0;

    task automatic check(string tag, logic [TOT-1:0] act, logic [TOT-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic shift_bit(logic b);
        sdin = b;
        #1;
        sclk = 1;
        mdl = {mdl[TOT-2:0], b};
        #(CLK_PERIOD/2 - 1);
        sclk = 0;
        #(CLK_PERIOD/2);
    endtask

    task automatic store(string tag);
        exp_t e;
        e.v = mdl; e.tag = tag;
        sb.push_back(e);
        stclk = 1;
        #(CLK_PERIOD/2);
        stclk = 0;
        #(CLK_PERIOD/2);
    endtask

    task automatic both_pulse(logic b, string tag);
        exp_t e;
        sdin = b;
        #1;
        e.v = mdl; e.tag = tag;
        sb.push_back(e);
        mdl = {mdl[TOT-2:0], b};
        sclk = 1; stclk = 1;
        #(CLK_PERIOD/2 - 1);
        sclk = 0; stclk = 0;
        #(CLK_PERIOD/2);
    endtask

    // Monitor: pops the expected snapshot after each store edge
    always @(posedge stclk) begin
        #(CLK_PERIOD/4);
        if (sb.size() == 0) begin
            checks++; errors++;
            $display("FAIL R2 actual=%h expected=<none queued>", q_o);
        end else begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, q_o, e.v);
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [TOT-1:0] held;
        #(CLK_PERIOD);
        check("R4 sout in clear", {{(TOT-1){1'b0}}, sout}, '0);
        check("R6 enables off", q_en_o, '0);
        clr_n = 1;
        #(CLK_PERIOD);
        store("R7 store after clear");
        oe_n = 0;
        #1;
        check("R6 enables on", q_en_o, '1);
        check("R6 pad drives", q_io, q_o);

        // R9: walk a single one through the cascade
        shift_bit(1'b1);
        for (int i = 0; i < STAGES - 1; i++) shift_bit(1'b0);
        store("R9 unit boundary");
        check("R9 bit at q_o[7]", {{(TOT-1){1'b0}}, q_o[STAGES-1]}, 1);
        for (int i = 0; i < TOT - STAGES - 1; i++) shift_bit(1'b0);
        check("R9 sout before arrival", {{(TOT-1){1'b0}}, sout}, '0);
        shift_bit(1'b0);
        check("R9 sout at 8xUNITS", {{(TOT-1){1'b0}}, sout}, 1);

        // R10 / R1: full streams
        for (int i = TOT - 1; i >= 0; i--) shift_bit(16'hA5C3 >> i);
        store("R10 stream A5C3");
        for (int i = TOT - 1; i >= 0; i--) shift_bit(16'h3C69 >> i);
        store("R10 stream 3C69");
        shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
        store("R1 partial shift");
        check("R5 sout tracks top", {{(TOT-1){1'b0}}, sout}, {{(TOT-1){1'b0}}, mdl[TOT-1]});

        // R3: common clock lag
        both_pulse(1'b1, "R3 common clock");
        both_pulse(1'b0, "R3 common clock");
        both_pulse(1'b1, "R3 common clock");

        // R6 / R8: enable high releases outputs, serial path unaffected
        held = q_o;
        oe_n = 1;
        #1;
        check("R6 released", q_en_o, '0);
        shift_bit(1'b1);
        check("R8 sout ungated", {{(TOT-1){1'b0}}, sout}, {{(TOT-1){1'b0}}, mdl[TOT-1]});
        oe_n = 0;
        #1;
        check("R6 hold kept", q_o, held);
        check("R6 pad drives", q_io, q_o);

        // R7 / R8 / R4: clear with nonzero held word
        while (mdl[TOT-1] == 1'b0) shift_bit(1'b1);
        store("R2 before clear");
        held = q_o;
        clr_n = 0;
        #1;
        mdl = '0;
        check("R8 sout drops at once", {{(TOT-1){1'b0}}, sout}, '0);
        check("R7 hold survives clear", q_o, held);
        #(CLK_PERIOD);
        clr_n = 1;
        #(CLK_PERIOD);
        store("R7 zeros after clear");

        #(CLK_PERIOD);
        check("R2 queue drained", TOT'(sb.size()), '0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule